// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block sits between decode and issue in an out-of-order core. Each clock it may take a group of four instructions. Each instruction names one architectural destination and two architectural sources. One cycle later the block returns twelve physical register numbers: a destination and two sources for every lane. Each written destination receives a physical register taken fresh from a circular free queue. Sources are translated through a map table. A source that names a register written by an older lane of the same group is steered to that lane's new register instead of the table entry.

Every accepted group carries a stamp from a running counter. Before the group's writes land, the block saves a copy of the map table and the free-queue head, indexed by the low bits of that stamp. A rollback input names a stamp. In one cycle it puts back the state that existed just before that group, and it drops everything younger. Registers retired at commit come back through a one-per-cycle return port that appends to the tail of the free queue.

Top module: `rename_stage4`

## Requirements
- R1: An accepted group (grp_valid high, grp_stall low, rb_en low) appears on the ren_* outputs with ren_valid high exactly one clock later. ren_valid is low in every other cycle.
- R2: A lane writes when its enable bit is set and its destination is not zero. Writing lanes take registers from the free-queue head in lane order, lane 0 first. A lane that does not write reports destination 0.
- R3: A source with no older writer of the same register in its group is translated through the map table as it stood before the group.
- R4: A source that matches the destination of an older writing lane in the same group takes the physical register of the nearest such older lane.
- R5: When several lanes of one group write the same architectural register, the map table keeps the youngest lane's register.
- R6: Architectural register 0 always translates to physical register 0. It is never allocated and never remapped.
- R7: If fewer registers are free than the group needs, grp_stall is high in that cycle and the group is not renamed. Map table, free queue and stamp stay as they were.
- R8: A register presented on ret_preg with ret_en high joins the tail of the free queue. It is handed out after all registers already queued.
- R9: With rb_en high, the map table and free-queue head return to their values just before the group stamped rb_stamp, and the stamp counter becomes rb_stamp. A group presented in the same cycle is discarded and produces no output.
- R10: After reset, architectural register i maps to physical register i. The free queue holds physical registers 32 to 63 in ascending order, the stamp counter is 0 and ren_valid is low.
- R11: ren_stamp carries the stamp of the group being reported. The stamp counter advances by one per accepted group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is presented this cycle |
| grp_dst_en | input | 4 | Per-lane destination write enable |
| grp_dst | input | 20 | Destination architectural registers, lane i at bits [5i+4:5i] |
| grp_src_a | input | 20 | First source architectural registers, same packing |
| grp_src_b | input | 20 | Second source architectural registers, same packing |
| grp_stall | output | 1 | Group held back for lack of free registers |
| ret_en | input | 1 | Return one physical register to the free queue |
| ret_preg | input | 6 | Physical register being returned |
| rb_en | input | 1 | Roll back to a stamped checkpoint |
| rb_stamp | input | 8 | Stamp of the group to roll back to |
| ren_valid | output | 1 | Renamed group is on the outputs |
| ren_stamp | output | 8 | Stamp of the renamed group |
| ren_pdst | output | 24 | Physical destinations, lane i at bits [6i+5:6i] |
| ren_psrc_a | output | 24 | Physical first sources, same packing |
| ren_psrc_b | output | 24 | Physical second sources, same packing |

## Verification
The bench targets a group where three lanes touch one register. A bypass that picked the oldest writer, or the table, would hand lane 3 a stale register. A later read-only group then shows whether the table kept the youngest writer or the oldest. The free queue is drained to exactly the group's need and then one past it. An off-by-one in the stall compare would either stall a group that fits or hand out registers that are not free. After a rollback taken while a group is presented, the same group is replayed and the rolled-back architectural registers are read. A design that saved the checkpoint after the group's writes, or that failed to drop the concurrent group, returns the wrong registers.

// File: rtl/rename_pkg.sv
package rename_pkg;
    parameter int NUM_ARCH = 32;
    parameter int NUM_PHYS = 64;
    parameter int LANES    = 4;
    parameter int NUM_CKPT = 4;
    parameter int STAMP_W  = 8;

    localparam int AW    = $clog2(NUM_ARCH);
    localparam int PW    = $clog2(NUM_PHYS);
    localparam int PTR_W = PW + 1;
    localparam int CK_W  = $clog2(NUM_CKPT);
    localparam int CNT_W = $clog2(LANES + 1);
    localparam int LN_W  = $clog2(LANES);

    typedef logic [AW-1:0]      arch_t;
    typedef logic [PW-1:0]      phys_t;
    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [CK_W-1:0]    ck_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [STAMP_W-1:0] stamp_t;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
    import rename_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  cnt_t                   take_cnt,
    input  logic                   give,
    input  phys_t                  give_reg,
    input  logic                   rewind,
    input  ptr_t                   rewind_head,
    output ptr_t                   head,
    output ptr_t                   avail,
    output phys_t [LANES-1:0]      peek
);
    typedef struct packed {
        phys_t [NUM_PHYS-1:0] slots;
        ptr_t                 head;
        ptr_t                 tail;
    } fl_s;

    fl_s fl_q, fl_d;

    function automatic fl_s fl_init();
        fl_s v;
        v = '0;
        for (int k = 0; k < NUM_PHYS - NUM_ARCH; k++)
            v.slots[k] = phys_t'(k + NUM_ARCH);
        v.tail = ptr_t'(NUM_PHYS - NUM_ARCH);
        return v;
    endfunction

    always_comb begin
        fl_d = fl_q;
        if (rewind)
            fl_d.head = rewind_head;
        else if (take)
            fl_d.head = fl_q.head + ptr_t'(take_cnt);
        if (give) begin
            fl_d.slots[fl_q.tail[PW-1:0]] = give_reg;
            fl_d.tail = fl_q.tail + ptr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= fl_init();
        else        fl_q <= fl_d;
    end

    always_comb begin
        ptr_t idx;
        for (int i = 0; i < LANES; i++) begin
            idx     = fl_q.head + ptr_t'(i);
            peek[i] = fl_q.slots[idx[PW-1:0]];
        end
    end

    assign head  = fl_q.head;
    assign avail = fl_q.tail - fl_q.head;

    // R7
    take_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (avail >= ptr_t'(take_cnt)));

    // R8
    give_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take && !rewind) |-> (avail < ptr_t'(NUM_PHYS - 1)));
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable
    import rename_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       wr_en,
    input  arch_t [LANES-1:0]      wr_arch,
    input  phys_t [LANES-1:0]      wr_phys,
    input  logic                   snap_en,
    input  ck_t                    snap_slot,
    input  ptr_t                   snap_head,
    input  logic                   rewind,
    input  ck_t                    rewind_slot,
    output phys_t [NUM_ARCH-1:0]   map,
    output ptr_t                   rewind_head
);
    typedef struct packed {
        phys_t [NUM_ARCH-1:0]                map;
        phys_t [NUM_CKPT-1:0][NUM_ARCH-1:0]  ck_map;
        ptr_t  [NUM_CKPT-1:0]                ck_head;
    } mt_s;

    mt_s mt_q, mt_d;

    function automatic mt_s mt_init();
        mt_s v;
        v = '0;
        for (int k = 0; k < NUM_ARCH; k++)
            v.map[k] = phys_t'(k);
        return v;
    endfunction

    always_comb begin
        mt_d = mt_q;
        if (rewind) begin
            mt_d.map = mt_q.ck_map[rewind_slot];
        end else begin
            if (snap_en) begin
                mt_d.ck_map[snap_slot]  = mt_q.map;
                mt_d.ck_head[snap_slot] = snap_head;
            end
            for (int i = 0; i < LANES; i++)
                if (wr_en[i]) mt_d.map[wr_arch[i]] = wr_phys[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mt_q <= mt_init();
        else        mt_q <= mt_d;
    end

    assign map         = mt_q.map;
    assign rewind_head = mt_q.ck_head[rewind_slot];

    // R6
    zero_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mt_q.map[0] == '0);
endmodule

// File: rtl/rn_lanes.sv
module rn_lanes
    import rename_pkg::*;
(
    input  phys_t [NUM_ARCH-1:0]   map,
    input  logic  [LANES-1:0]      dst_en,
    input  arch_t [LANES-1:0]      dst,
    input  arch_t [LANES-1:0]      src_a,
    input  arch_t [LANES-1:0]      src_b,
    input  phys_t [LANES-1:0]      peek,
    output logic  [LANES-1:0]      writes,
    output cnt_t                   need,
    output phys_t [LANES-1:0]      pdst,
    output phys_t [LANES-1:0]      qa,
    output phys_t [LANES-1:0]      qb
);
    always_comb begin
        cnt_t k;
        k = '0;
        for (int i = 0; i < LANES; i++) begin
            writes[i] = dst_en[i] && (dst[i] != '0);
            pdst[i]   = '0;
            if (writes[i]) begin
                pdst[i] = peek[k[LN_W-1:0]];
                k       = k + cnt_t'(1);
            end
        end
        need = k;
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            qa[i] = map[src_a[i]];
            qb[i] = map[src_b[i]];
            for (int j = 0; j < LANES; j++) begin
                if (j < i && writes[j]) begin
                    if (dst[j] == src_a[i]) qa[i] = pdst[j];
                    if (dst[j] == src_b[i]) qb[i] = pdst[j];
                end
            end
        end
    end
endmodule

// File: rtl/rename_stage4.sv
module rename_stage4
    import rename_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grp_valid,
    input  logic [LANES-1:0]         grp_dst_en,
    input  logic [LANES*AW-1:0]      grp_dst,
    input  logic [LANES*AW-1:0]      grp_src_a,
    input  logic [LANES*AW-1:0]      grp_src_b,
    output logic                     grp_stall,
    input  logic                     ret_en,
    input  logic [PW-1:0]            ret_preg,
    input  logic                     rb_en,
    input  logic [STAMP_W-1:0]       rb_stamp,
    output logic                     ren_valid,
    output logic [STAMP_W-1:0]       ren_stamp,
    output logic [LANES*PW-1:0]      ren_pdst,
    output logic [LANES*PW-1:0]      ren_psrc_a,
    output logic [LANES*PW-1:0]      ren_psrc_b
);
    typedef struct packed {
        logic              out_valid;
        stamp_t            out_stamp;
        stamp_t            stamp;
        phys_t [LANES-1:0] pdst;
        phys_t [LANES-1:0] qa;
        phys_t [LANES-1:0] qb;
    } st_s;

    st_s st_q, st_d;

    arch_t [LANES-1:0]    dst_v, sa_v, sb_v;
    phys_t [LANES-1:0]    peek, pdst_c, qa_c, qb_c;
    phys_t [NUM_ARCH-1:0] map;
    logic  [LANES-1:0]    writes;
    cnt_t                 need;
    ptr_t                 avail, fl_head, ck_head;
    logic                 short_regs, accept;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign dst_v[g] = grp_dst[g*AW +: AW];
        assign sa_v[g]  = grp_src_a[g*AW +: AW];
        assign sb_v[g]  = grp_src_b[g*AW +: AW];
        assign ren_pdst[g*PW +: PW]   = st_q.pdst[g];
        assign ren_psrc_a[g*PW +: PW] = st_q.qa[g];
        assign ren_psrc_b[g*PW +: PW] = st_q.qb[g];
    end

    rn_lanes u_lanes (
        .map(map), .dst_en(grp_dst_en), .dst(dst_v), .src_a(sa_v), .src_b(sb_v),
        .peek(peek), .writes(writes), .need(need), .pdst(pdst_c), .qa(qa_c), .qb(qb_c)
    );

    assign short_regs = avail < ptr_t'(need);
    assign grp_stall  = grp_valid && !rb_en && short_regs;
    assign accept     = grp_valid && !rb_en && !short_regs;

    rn_freelist u_free (
        .clk(clk), .rst_n(rst_n), .take(accept), .take_cnt(need),
        .give(ret_en), .give_reg(ret_preg), .rewind(rb_en), .rewind_head(ck_head),
        .head(fl_head), .avail(avail), .peek(peek)
    );

    rn_maptable u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(writes & {LANES{accept}}), .wr_arch(dst_v),
        .wr_phys(pdst_c), .snap_en(accept), .snap_slot(st_q.stamp[CK_W-1:0]),
        .snap_head(fl_head), .rewind(rb_en), .rewind_slot(rb_stamp[CK_W-1:0]),
        .map(map), .rewind_head(ck_head)
    );

    always_comb begin
        st_d = st_q;
        st_d.out_valid = accept;
        if (accept) begin
            st_d.out_stamp = st_q.stamp;
            st_d.pdst      = pdst_c;
            st_d.qa        = qa_c;
            st_d.qb        = qb_c;
            st_d.stamp     = st_q.stamp + stamp_t'(1);
        end
        if (rb_en) st_d.stamp = rb_stamp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ren_valid = st_q.out_valid;
    assign ren_stamp = st_q.out_stamp;

    logic dup_dst;
    always_comb begin
        dup_dst = 1'b0;
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < LANES; j++)
                if (i < j && st_q.pdst[i] != '0 && st_q.pdst[i] == st_q.pdst[j])
                    dup_dst = 1'b1;
    end

    // R2
    fresh_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid |-> !dup_dst);

    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stall |=> !ren_valid);

    // R9
    rollback_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_en |=> !ren_valid);
endmodule

// File: tb/rename_stage4_test.sv
module rename_stage4_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_valid = 1'b0;
    logic [3:0]  grp_dst_en = '0;
    logic [19:0] grp_dst = '0, grp_src_a = '0, grp_src_b = '0;
    logic        grp_stall;
    logic        ret_en = 1'b0;
    logic [5:0]  ret_preg = '0;
    logic        rb_en = 1'b0;
    logic [7:0]  rb_stamp = '0;
    logic        ren_valid;
    logic [7:0]  ren_stamp;
    logic [23:0] ren_pdst, ren_psrc_a, ren_psrc_b;

    always #5 clk = ~clk;

    rename_stage4 uut (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_dst_en(grp_dst_en),
        .grp_dst(grp_dst), .grp_src_a(grp_src_a), .grp_src_b(grp_src_b),
        .grp_stall(grp_stall), .ret_en(ret_en), .ret_preg(ret_preg),
        .rb_en(rb_en), .rb_stamp(rb_stamp), .ren_valid(ren_valid),
        .ren_stamp(ren_stamp), .ren_pdst(ren_pdst), .ren_psrc_a(ren_psrc_a),
        .ren_psrc_b(ren_psrc_b)
    );

    typedef struct packed {
        logic [7:0]       st;
        logic [3:0][5:0]  pd;
        logic [3:0][5:0]  qa;
        logic [3:0][5:0]  qb;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_bad = 0;

    int bmap[32];
    int fmem[64];
    int fh, ft, stamp;
    int ckmap[4][32];
    int ckh[4];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && ren_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R1", "unexpected ren_valid", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ren_stamp == e.st, "R11", "stamp", ren_stamp, e.st);
                for (int i = 0; i < 4; i++) begin
                    check(ren_pdst[i*6 +: 6] == e.pd[i], t, $sformatf("pdst lane %0d", i),
                          ren_pdst[i*6 +: 6], e.pd[i]);
                    check(ren_psrc_a[i*6 +: 6] == e.qa[i], t, $sformatf("src_a lane %0d", i),
                          ren_psrc_a[i*6 +: 6], e.qa[i]);
                    check(ren_psrc_b[i*6 +: 6] == e.qb[i], t, $sformatf("src_b lane %0d", i),
                          ren_psrc_b[i*6 +: 6], e.qb[i]);
                end
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 32; i++) bmap[i] = i;
        for (int k = 0; k < 64; k++) fmem[k] = (k < 32) ? k + 32 : 0;
        fh = 0; ft = 32; stamp = 0;
    endtask

    task automatic drive_group(input logic [3:0] en, input int d[4], input int a[4], input int b[4]);
        grp_valid  = 1'b1;
        grp_dst_en = en;
        for (int i = 0; i < 4; i++) begin
            grp_dst[i*5 +: 5]   = 5'(d[i]);
            grp_src_a[i*5 +: 5] = 5'(a[i]);
            grp_src_b[i*5 +: 5] = 5'(b[i]);
        end
    endtask

    task automatic send(input logic [3:0] en, input int d[4], input int a[4],
                        input int b[4], input string tag);
        int   need, k;
        bit   stall_x;
        exp_t e;
        @(negedge clk);
        drive_group(en, d, a, b);
        #1;
        need = 0;
        for (int i = 0; i < 4; i++) if (en[i] && d[i] != 0) need++;
        stall_x = (ft - fh) < need;
        check(grp_stall == stall_x, "R7", "grp_stall", grp_stall, stall_x);
        if (!stall_x) begin
            k = 0;
            e.st = 8'(stamp);
            for (int i = 0; i < 4; i++) begin
                e.pd[i] = '0;
                if (en[i] && d[i] != 0) begin
                    e.pd[i] = 6'(fmem[(fh + k) % 64]);
                    k++;
                end
            end
            for (int i = 0; i < 4; i++) begin
                e.qa[i] = 6'(bmap[a[i]]);
                e.qb[i] = 6'(bmap[b[i]]);
                for (int j = 0; j < i; j++) begin
                    if (en[j] && d[j] != 0 && d[j] == a[i]) e.qa[i] = e.pd[j];
                    if (en[j] && d[j] != 0 && d[j] == b[i]) e.qb[i] = e.pd[j];
                end
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
            ckmap[stamp % 4] = bmap;
            ckh[stamp % 4]   = fh;
            for (int i = 0; i < 4; i++)
                if (en[i] && d[i] != 0) bmap[d[i]] = e.pd[i];
            fh    = fh + need;
            stamp = (stamp + 1) % 256;
        end
        @(posedge clk);
        #1 grp_valid = 1'b0;
    endtask

    task automatic give_back(input int p);
        @(negedge clk);
        ret_en = 1'b1; ret_preg = 6'(p);
        fmem[ft % 64] = p;
        ft++;
        @(posedge clk);
        #1 ret_en = 1'b0;
    endtask

    task automatic rollback(input int rs);
        @(negedge clk);
        rb_en = 1'b1; rb_stamp = 8'(rs);
        drive_group(4'b1111, '{3, 4, 5, 6}, '{1, 2, 3, 4}, '{5, 6, 7, 8});
        #1 check(grp_stall == 1'b0, "R9", "stall during rollback", grp_stall, 0);
        bmap  = ckmap[rs % 4];
        fh    = ckh[rs % 4];
        stamp = rs;
        @(posedge clk);
        #1 begin rb_en = 1'b0; grp_valid = 1'b0; end
        @(negedge clk);
        check(ren_valid == 1'b0, "R9", "group in rollback cycle dropped", ren_valid, 0);
    endtask

    bit finished = 0;

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R1 no output without a group
        check(ren_valid == 1'b0, "R10", "ren_valid after reset", ren_valid, 0);
        check(grp_stall == 1'b0, "R10", "grp_stall after reset", grp_stall, 0);

        send(4'b1111, '{1, 2, 3, 4}, '{5, 6, 7, 8}, '{0, 9, 10, 11}, "R2/R3/R10");
        send(4'b1111, '{5, 6, 5, 7}, '{1, 5, 5, 5}, '{5, 6, 2, 6}, "R4");
        send(4'b1111, '{0, 8, 0, 9}, '{0, 0, 8, 0}, '{0, 8, 9, 0}, "R6");
        send(4'b0000, '{5, 6, 1, 2}, '{5, 6, 1, 2}, '{7, 8, 9, 0}, "R5");
        for (int g = 0; g < 5; g++)
            send(4'b1111, '{10 + g, 11 + g, 12 + g, 13 + g}, '{g, 1, 2, 3}, '{4, 5, 6, g}, "R1");
        // 2 left: a 4-writer group stalls, a 2-writer group fits exactly
        send(4'b1111, '{20, 21, 22, 23}, '{1, 2, 3, 4}, '{5, 6, 7, 8}, "R7");
        send(4'b0101, '{20, 21, 22, 23}, '{20, 21, 22, 23}, '{1, 2, 3, 4}, "R7");
        send(4'b0001, '{24, 0, 0, 0}, '{1, 2, 3, 4}, '{5, 6, 7, 8}, "R7");
        for (int p = 32; p < 40; p++) give_back(p);
        send(4'b1111, '{25, 26, 27, 28}, '{25, 26, 27, 28}, '{22, 20, 1, 0}, "R8");
        s0 = stamp;
        send(4'b1001, '{29, 0, 0, 30}, '{29, 1, 2, 29}, '{3, 4, 5, 30}, "R9");
        send(4'b0011, '{20, 21, 0, 0}, '{20, 21, 1, 2}, '{3, 4, 5, 6}, "R9");
        rollback(s0);
        send(4'b1001, '{29, 0, 0, 30}, '{29, 1, 2, 29}, '{3, 4, 5, 30}, "R9");
        send(4'b0000, '{0, 0, 0, 0}, '{20, 21, 29, 30}, '{22, 25, 0, 28}, "R9");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1", "outstanding groups", exp_q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule